// File: doc/BRIEF.md
# SPI Serial Clock Divider with Linear and Power-of-Two Modes

This block derives the serial clock of an SPI shift engine from the module clock. The engine's clock control word arrives as a 32-bit register write. One select bit in that word picks the divide scheme. In linear mode an 8-bit count gives an even divide of 2*(N+1). In power-of-two mode a 4-bit exponent gives a divide of 2^N. Both settings sit in the same word, and only the one that the select bit names is used.

While a transfer runs, the block counts half-periods of the serial clock. At the end of each half-period it raises a one-cycle strobe, and the serial clock output flips on the clock edge that ends that cycle. A second flag marks the strobes that move the clock away from its idle level (the leading edges), so the shift engine can tell its sample edges from its launch edges. When no transfer is active, the counter is held at its reload value and the clock rests at the idle level. A new control word changes the rate only at a half-period boundary, so a write never produces a shortened pulse.

Top module: `spiclk_div`

## Requirements
- R1: During reset and in the cycle after it, `sclk` equals `idle_lvl` and `edge_stb` and `edge_lead` are low.
- R2: With bit 12 of the control word set (linear mode), each half-period lasts N+1 module clock cycles, where N is bits 7:0. The serial period is therefore 2*(N+1). Bits 11:8 have no effect in this mode.
- R3: With bit 12 clear (power-of-two mode), each half-period lasts 2^(N-1) cycles, where N is bits 11:8. The serial period is therefore 2^N. N=0 and N=1 both give a divide by 2. Bits 7:0 have no effect in this mode.
- R4: Bits 31:13 of the control word have no effect on the rate or the mode.
- R5: `edge_stb` pulses for one cycle at the end of every half-period. `sclk` flips on the edge that ends a strobe cycle and holds otherwise. Under a constant setting, all half-periods are equal (50% duty).
- R6: A control write never shortens the half-period in progress. The new setting applies from the next half-period boundary after the write is captured. A write captured on the same edge as a boundary reload applies one boundary later.
- R7: While `xfer_en` is low, there is no strobe and `sclk` returns to `idle_lvl` on the next edge. The count restarts, so the first half-period after `xfer_en` rises has full length.
- R8: `edge_lead` is high exactly on the strobes that move `sclk` away from `idle_lvl`: the 1st, 3rd, 5th and later odd strobes after a start. `idle_lvl` must stay stable while `xfer_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the clock control word |
| cfg_wdata | input | 32 | Clock control word: bits 7:0 linear count, bits 11:8 exponent, bit 12 mode select (1 = linear) |
| xfer_en | input | 1 | High while a transfer runs |
| idle_lvl | input | 1 | Level of `sclk` while idle |
| sclk | output | 1 | Serial clock |
| edge_stb | output | 1 | One-cycle strobe at each half-period end |
| edge_lead | output | 1 | Strobe that moves `sclk` away from idle |

## Verification
A control write and a half-period boundary can land in the same cycle. The open question is whether the reload uses the old setting or the new one. The bench waits until it sees `edge_stb` high just after a clock edge and then drives the write at once, so the write is captured on the edge that performs the reload. The scoreboard expects one more half-period at the old length before the new length takes over. A second run places a write in the middle of a half-period and expects the current half to finish unchanged.

// File: rtl/spiclk_pkg.sv
// Shared types and default field layout for the serial clock divider.
// Assumes the exponent field is at least 2 bits wide.
package spiclk_pkg;

    typedef enum logic {
        DIV_POW2   = 1'b0,
        DIV_LINEAR = 1'b1
    } div_mode_e;

    localparam int unsigned CFG_REG_W     = 32;
    localparam int unsigned LIN_FIELD_W   = 8;
    localparam int unsigned POW_FIELD_W   = 4;
    localparam int unsigned LIN_FIELD_LSB = 0;
    localparam int unsigned POW_FIELD_LSB = 8;
    localparam int unsigned MODE_BIT      = 12;

    // Counter width that holds the largest half-period minus one in either mode
    function automatic int unsigned cnt_width(input int unsigned lin_w, input int unsigned pow_w);
        int unsigned pw;
        pw = (2 ** pow_w) - 2;
        return (lin_w > pw) ? lin_w : pw;
    endfunction

endpackage

// File: rtl/spiclk_cfg_reg.sv
// Holds the divider setting decoded from the clock control word.
// Assumes the field positions fit inside REG_W. Reset selects linear mode with count 0.
module spiclk_cfg_reg
    import spiclk_pkg::*;
#(
    parameter int unsigned REG_W   = CFG_REG_W,
    parameter int unsigned LIN_W   = LIN_FIELD_W,
    parameter int unsigned POW_W   = POW_FIELD_W,
    parameter int unsigned LIN_LSB = LIN_FIELD_LSB,
    parameter int unsigned POW_LSB = POW_FIELD_LSB,
    parameter int unsigned SEL_BIT = MODE_BIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output div_mode_e        mode,
    output logic [LIN_W-1:0] lin_n,
    output logic [POW_W-1:0] pow_n
);

    logic unused_wr;
    assign unused_wr = ^wr_data;

    // Capture mode and both divide fields on a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode  <= DIV_LINEAR;
            lin_n <= '0;
            pow_n <= '0;
        end else if (wr_en) begin
            mode  <= div_mode_e'(wr_data[SEL_BIT]);
            lin_n <= wr_data[LIN_LSB +: LIN_W];
            pow_n <= wr_data[POW_LSB +: POW_W];
        end
    end

endmodule

// File: rtl/spiclk_reload_calc.sv
// Turns the held setting into a counter reload value: half-period length minus one.
// Purely combinational. The exponent table is built by a generate loop.
module spiclk_reload_calc
    import spiclk_pkg::*;
#(
    parameter int unsigned LIN_W = LIN_FIELD_W,
    parameter int unsigned POW_W = POW_FIELD_W,
    parameter int unsigned CNT_W = cnt_width(LIN_FIELD_W, POW_FIELD_W)
) (
    input  div_mode_e        mode,
    input  logic [LIN_W-1:0] lin_n,
    input  logic [POW_W-1:0] pow_n,
    output logic [CNT_W-1:0] reload
);

    localparam int unsigned POW_CODES = 2 ** POW_W;

    logic [CNT_W-1:0] pow_tab [POW_CODES];

    // One entry per exponent: half-period 2^(k-1), with k = 0 and k = 1 clamped to 1 cycle
    for (genvar k = 0; k < POW_CODES; k++) begin : g_pow
        if (k <= 1) begin : g_min
            assign pow_tab[k] = '0;
        end else begin : g_shift
            assign pow_tab[k] = CNT_W'((64'd1 << (k - 1)) - 64'd1);
        end
    end

    // Pick the reload for the active mode
    always_comb begin
        if (mode == DIV_LINEAR) reload = CNT_W'(lin_n);
        else                    reload = pow_tab[pow_n];
    end

endmodule

// File: rtl/spiclk_tgen.sv
// Half-period counter and clock toggle. Counts down from the reload value while run
// is high. The strobe is combinational on a zero count. A new reload is taken only
// at a boundary or while idle.
module spiclk_tgen #(
    parameter int unsigned CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             idle_lvl,
    input  logic [CNT_W-1:0] reload,
    output logic             sclk,
    output logic             stb,
    output logic             lead
);

    logic [CNT_W-1:0] cnt;
    logic             phase_q;

    assign stb  = run && (cnt == '0);
    assign lead = stb && !phase_q;

    // Half-period down-counter, reloaded at each boundary and held while idle
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= reload;
        else if (!run)       cnt <= reload;
        else if (cnt == '0)  cnt <= reload;
        else                 cnt <= cnt - CNT_W'(1);
    end

    // Serial clock level: idle level while stopped, flip at each boundary
    always_ff @(posedge clk) begin
        if (!rst_n)      sclk <= idle_lvl;
        else if (!run)   sclk <= idle_lvl;
        else if (stb)    sclk <= ~sclk;
    end

    // Edge parity: 0 means the next strobe leaves the idle level
    always_ff @(posedge clk) begin
        if (!rst_n)      phase_q <= 1'b0;
        else if (!run)   phase_q <= 1'b0;
        else if (stb)    phase_q <= ~phase_q;
    end

endmodule

// File: rtl/spiclk_div.sv
// Top of the serial clock divider: control word register, reload calculation and
// toggle generator. Assumes idle_lvl is stable while xfer_en is high.
module spiclk_div
    import spiclk_pkg::*;
#(
    parameter int unsigned REG_W   = CFG_REG_W,
    parameter int unsigned LIN_W   = LIN_FIELD_W,
    parameter int unsigned POW_W   = POW_FIELD_W,
    parameter int unsigned LIN_LSB = LIN_FIELD_LSB,
    parameter int unsigned POW_LSB = POW_FIELD_LSB,
    parameter int unsigned SEL_BIT = MODE_BIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             xfer_en,
    input  logic             idle_lvl,
    output logic             sclk,
    output logic             edge_stb,
    output logic             edge_lead
);

    localparam int unsigned CNT_W = cnt_width(LIN_W, POW_W);

    div_mode_e        mode;
    logic [LIN_W-1:0] lin_n;
    logic [POW_W-1:0] pow_n;
    logic [CNT_W-1:0] reload;

    spiclk_cfg_reg #(
        .REG_W(REG_W), .LIN_W(LIN_W), .POW_W(POW_W),
        .LIN_LSB(LIN_LSB), .POW_LSB(POW_LSB), .SEL_BIT(SEL_BIT)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_data(cfg_wdata),
        .mode(mode), .lin_n(lin_n), .pow_n(pow_n)
    );

    spiclk_reload_calc #(
        .LIN_W(LIN_W), .POW_W(POW_W), .CNT_W(CNT_W)
    ) u_calc (
        .mode(mode), .lin_n(lin_n), .pow_n(pow_n), .reload(reload)
    );

    spiclk_tgen #(
        .CNT_W(CNT_W)
    ) u_tgen (
        .clk(clk), .rst_n(rst_n), .run(xfer_en), .idle_lvl(idle_lvl),
        .reload(reload), .sclk(sclk), .stb(edge_stb), .lead(edge_lead)
    );

endmodule

// File: rtl/spiclk_div_chk.sv
// Temporal checks on the divider ports, attached to every spiclk_div by bind.
module spiclk_div_chk (
    input logic clk,
    input logic rst_n,
    input logic xfer_en,
    input logic idle_lvl,
    input logic sclk,
    input logic edge_stb,
    input logic edge_lead
);

    // R5: a strobe flips the clock on the following edge
    p_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        edge_stb |=> (sclk != $past(sclk)));

    // R5: without a strobe a running clock holds its level
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_en && !edge_stb) |=> $stable(sclk));

    // R7: stopping returns the clock to the idle level
    p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_en |=> (sclk == $past(idle_lvl)));

    // R7: no strobe while stopped
    p_nostb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_en |-> !edge_stb);

    // R8: leading flag only together with a strobe
    p_lead_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        edge_lead |-> edge_stb);

    // R8: leading flag marks strobes that leave the idle level
    p_lead_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_stb && $stable(idle_lvl)) |-> (edge_lead == (sclk == idle_lvl)));

endmodule

bind spiclk_div spiclk_div_chk u_chk (
    .clk(clk), .rst_n(rst_n), .xfer_en(xfer_en), .idle_lvl(idle_lvl),
    .sclk(sclk), .edge_stb(edge_stb), .edge_lead(edge_lead)
);

// File: tb/spiclk_div_tb.sv
// Scoreboard bench: a driver pushes expected half-period lengths and a monitor
// measures the gap between strobes and pops them.
module spiclk_div_tb;

    typedef struct {
        int    half;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        xfer_en = 1'b0;
    logic        idle_lvl = 1'b0;
    logic        sclk, edge_stb, edge_lead;

    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    spiclk_div u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .xfer_en(xfer_en), .idle_lvl(idle_lvl),
        .sclk(sclk), .edge_stb(edge_stb), .edge_lead(edge_lead)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: measure strobe gaps, check toggling and the leading flag
    int   gap = 0;
    int   nstb = 0;
    logic pstb = 1'b0;
    logic psclk = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (pstb) chk(sclk !== psclk, "R5 toggle after strobe", sclk, ~psclk);
            if (!xfer_en) begin
                gap = 0;
                nstb = 0;
            end else begin
                gap++;
                if (edge_stb) begin
                    if (exp_q.size() > 0) begin
                        exp_t e;
                        e = exp_q.pop_front();
                        chk(gap == e.half, e.tag, gap, e.half);
                        chk(edge_lead == ((nstb % 2) == 0), "R8 leading flag", edge_lead, (nstb % 2) == 0);
                    end
                    nstb++;
                    gap = 0;
                end
            end
            pstb  = edge_stb;
            psclk = sclk;
        end
    end

    task automatic wr(input logic [31:0] d);
        @(posedge clk); #2;
        cfg_we = 1'b1;
        cfg_wdata = d;
        @(posedge clk); #2;
        cfg_we = 1'b0;
    endtask

    task automatic push(input int half, input int n, input string tag);
        for (int i = 0; i < n; i++) exp_q.push_back('{half, tag});
    endtask

    task automatic start();
        @(posedge clk); #2;
        xfer_en = 1'b1;
    endtask

    task automatic drain_stop();
        while (exp_q.size() > 0) @(posedge clk);
        #2;
        xfer_en = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    task automatic run_case(input logic [31:0] d, input int half, input int n, input string tag);
        wr(d);
        push(half, n, tag);
        start();
        drain_stop();
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(sclk == 1'b0, "R1 sclk idle in reset", sclk, 0);
        chk(edge_stb == 1'b0, "R1 no strobe in reset", edge_stb, 0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        @(negedge clk);
        chk(sclk == idle_lvl && !edge_stb && !edge_lead, "R1 after reset", {sclk, edge_stb, edge_lead}, 0);

        // R2 linear mode, exponent field filled with junk
        run_case(32'h0000_1A00, 1, 4, "R2 linear N=0");
        run_case(32'h0000_1503, 4, 4, "R2 linear N=3");
        run_case(32'h0000_1FFF, 256, 4, "R2 linear N=255");

        // R3 power-of-two mode, linear field filled with junk
        run_case(32'h0000_005A, 1, 4, "R3 pow N=0");
        run_case(32'h0000_01A5, 1, 4, "R3 pow N=1");
        run_case(32'h0000_04C3, 8, 4, "R3 pow N=4");
        run_case(32'h0000_0F11, 16384, 2, "R3 pow N=15");

        // R4 upper bits have no effect
        run_case(32'hFFFF_F305, 6, 4, "R4 upper bits ignored");

        // R7 idle holds the clock, also with a high idle level
        wr(32'h0000_1002);
        begin
            bit quiet = 1;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (edge_stb || sclk !== idle_lvl) quiet = 0;
            end
            chk(quiet, "R7 idle quiet", quiet, 1);
        end
        @(posedge clk); #2;
        idle_lvl = 1'b1;
        repeat (2) @(negedge clk);
        chk(sclk == 1'b1, "R7 sclk follows idle level", sclk, 1);
        push(3, 4, "R7 run with high idle");
        start();
        drain_stop();

        // R7 stop mid-half, then restart with full first half
        start();
        repeat (4) @(posedge clk);
        #2;
        xfer_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(sclk == 1'b1 && !edge_stb, "R7 stop returns idle", sclk, 1);
        push(3, 3, "R7 restart full half");
        start();
        drain_stop();
        @(posedge clk); #2;
        idle_lvl = 1'b0;
        repeat (2) @(posedge clk);

        // R6 write in mid half: current half completes, next uses new setting
        wr(32'h0000_1004);
        push(5, 2, "R6 mid write old");
        push(2, 3, "R6 mid write new");
        start();
        while (exp_q.size() > 4) @(posedge clk);
        wr(32'h0000_1001);
        drain_stop();

        // R6 write captured on the boundary edge: one more old half
        wr(32'h0000_1002);
        push(3, 3, "R6 coincident old");
        push(7, 2, "R6 coincident new");
        start();
        while (exp_q.size() > 4) @(posedge clk);
        forever begin
            @(posedge clk); #2;
            if (edge_stb) break;
        end
        cfg_we = 1'b1;
        cfg_wdata = 32'h0000_1006;
        @(posedge clk); #2;
        cfg_we = 1'b0;
        drain_stop();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule